// File: doc/BRIEF.md
# UART Task/Event Register Controller

This block is the software-facing control and status layer of a small UART peripheral that works in a task/event style. Software writes 32-bit words at word offsets. Writing the value 1 to a task offset starts or stops the transmit or receive side. Event flags record that receive data arrived, that a transmit byte was handed off, that a line error occurred, or that reception timed out. A single level interrupt line is raised when any event is flagged and its interrupt-enable bit is set.

The serialiser, baud generator, pin routing and receive buffer sit outside. The block reaches them through simple strobes. `rx_evt` reports that a byte is available and `rx_data` shows it. `brk` reports a break on the line. `tx_start` is a one-cycle request that carries the held byte on `tx_byte`, and `tx_done` reports that the serialiser has taken that byte. The peripheral stays dormant until a key value is written to its enable word. While it is dormant it reads as zero and ignores software.

Word offset map, used by every requirement below:

| Offset | Name |
|---|---|
| 0 | TX_GO |
| 1 | TX_HALT |
| 2 | RX_GO |
| 3 | RX_HALT |
| 4 | PAUSE |
| 8 | EV_RXRDY |
| 9 | EV_TXRDY |
| 10 | EV_ERR |
| 11 | EV_RXTO |
| 16 | IEN |
| 17 | IEN_SET |
| 18 | IEN_CLR |
| 20 | ERRSRC |
| 24 | ENABLE |
| 25 to 28 | pin selects 0 to 3 |
| 29 | BAUD |
| 30 | RXD |
| 31 | TXD |

Interrupt-enable bits: bit 0 is RXRDY, bit 1 is TXRDY, bit 2 is ERR and bit 3 is RXTO. An event word reads as its flag in bit 0.

Top module: `uart_evt_ctrl`

## Requirements
- R1: After reset the block is disabled and both directions are stopped. Once it is enabled, IEN, ERRSRC and all four events read 0, the four pin selects read 0xFFFFFFFF, BAUD reads 0x04000000, and irq and tx_start are 0.
- R2: Writing exactly 4 to ENABLE enables the block, and ENABLE then reads 4. Writing 0 disables it, stops TX and RX, and sets EV_RXTO. Any other value leaves every piece of state unchanged.
- R3: While the block is disabled, every read returns 0 and every write to an offset other than ENABLE has no effect.
- R4: A write to IEN replaces the 4-bit enable mask. A write to IEN_SET ORs the value's low 4 bits into the mask. A write to IEN_CLR clears the mask bits that are 1 in the value. Reads of IEN, IEN_SET and IEN_CLR all return the mask.
- R5: irq is 1 exactly when some event flag and its enable bit are both 1. It reflects a register write right after the clock edge that takes the write, so clearing an enabled event drops irq.
- R6: Writing the value 1 to TX_GO or RX_GO starts that direction. Any other value written to a task offset does nothing.
- R7: Writing 1 to TX_HALT stops only TX and leaves EV_RXTO unchanged. Writing 1 to RX_HALT stops RX and sets EV_RXTO.
- R8: Writing 1 to PAUSE stops both TX and RX and sets EV_RXTO.
- R9: A write to ERRSRC clears the bits that are 1 in the value. A brk pulse ORs 3 into ERRSRC and sets EV_ERR.
- R10: A write to EV_TXRDY, EV_ERR or EV_RXTO sets the flag when the value is nonzero and clears it when the value is zero. EV_RXRDY is cleared only by writing 0, and a nonzero write to it is ignored. rx_evt sets EV_RXRDY only while RX is started. RXD reads return rx_data, and writes to RXD are ignored.
- R11: A TXD write is accepted only while TX is started and no byte is pending. An accepted write pulses tx_start for exactly the cycle after the write, and tx_byte holds the low 8 bits of the value.
- R12: tx_done while a byte is pending clears the pending state and sets EV_TXRDY, and this set wins over a software write to EV_TXRDY in the same cycle. tx_done with no byte pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 5 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rx_evt | input | 1 | Receive buffer has a byte |
| rx_data | input | 8 | Byte at the head of the receive buffer |
| brk | input | 1 | Break detected on the line |
| tx_done | input | 1 | Serialiser has taken the held byte |
| tx_start | output | 1 | One-cycle request to send tx_byte |
| tx_byte | output | 8 | Held transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 4-bit error source, 8-bit bytes and four events. With these values the whole space of interrupt masks and event states is small enough to cover in full. It applies all 16 × 16 pairs of IEN writes and set-alias or clear-alias values, and all 16 × 16 pairs of event pattern and enable mask, checking irq against an OR of ANDs computed in the bench. It also sweeps ENABLE values 1 to 7 while the block is disabled, and writes to every offset while disabled to show that none of them has an effect.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
  localparam int OFF_W  = 5;
  localparam int DW     = 32;
  localparam int NUM_EV = 4;
  localparam int PSEL_N = 4;
  localparam int CFG_N  = PSEL_N + 1;

  localparam int EV_RXRDY = 0;
  localparam int EV_TXRDY = 1;
  localparam int EV_ERR   = 2;
  localparam int EV_RXTO  = 3;

  localparam logic [OFF_W-1:0] A_TX_GO    = 5'd0;
  localparam logic [OFF_W-1:0] A_TX_HALT  = 5'd1;
  localparam logic [OFF_W-1:0] A_RX_GO    = 5'd2;
  localparam logic [OFF_W-1:0] A_RX_HALT  = 5'd3;
  localparam logic [OFF_W-1:0] A_PAUSE    = 5'd4;
  localparam logic [OFF_W-1:0] A_EV_RXRDY = 5'd8;
  localparam logic [OFF_W-1:0] A_EV_TXRDY = 5'd9;
  localparam logic [OFF_W-1:0] A_EV_ERR   = 5'd10;
  localparam logic [OFF_W-1:0] A_EV_RXTO  = 5'd11;
  localparam logic [OFF_W-1:0] A_IEN      = 5'd16;
  localparam logic [OFF_W-1:0] A_IEN_SET  = 5'd17;
  localparam logic [OFF_W-1:0] A_IEN_CLR  = 5'd18;
  localparam logic [OFF_W-1:0] A_ERRSRC   = 5'd20;
  localparam logic [OFF_W-1:0] A_ENABLE   = 5'd24;
  localparam logic [OFF_W-1:0] A_PSEL0    = 5'd25;
  localparam logic [OFF_W-1:0] A_BAUD     = 5'd29;
  localparam logic [OFF_W-1:0] A_RXD      = 5'd30;
  localparam logic [OFF_W-1:0] A_TXD      = 5'd31;

  localparam logic [DW-1:0] EN_KEY   = 32'd4;
  localparam logic [DW-1:0] BAUD_RST = 32'h0400_0000;

  typedef logic [NUM_EV-1:0] ev_vec_t;

  // Offset of configuration word i (pin selects, then baud).
  function automatic logic [OFF_W-1:0] cfg_off(int i);
    return A_PSEL0 + OFF_W'(i);
  endfunction

  // Offset of event word i.
  function automatic logic [OFF_W-1:0] ev_off(int i);
    return A_EV_RXRDY + OFF_W'(i);
  endfunction

  // Next interrupt-enable mask: replace, then OR in, then clear.
  function automatic ev_vec_t ien_apply(ev_vec_t cur, ev_vec_t val,
                                        logic do_wr, logic do_set, logic do_clr);
    ev_vec_t n;
    n = cur;
    if (do_wr)  n = val;
    if (do_set) n = n | val;
    if (do_clr) n = n & ~val;
    return n;
  endfunction

  // Next event flags: software write rule, hardware set has priority.
  function automatic ev_vec_t ev_step(ev_vec_t cur, ev_vec_t sw_wr,
                                      logic [DW-1:0] val, ev_vec_t hw_set);
    ev_vec_t n;
    n = cur;
    for (int i = 0; i < NUM_EV; i++) begin
      if (sw_wr[i]) begin
        if (i == EV_RXRDY) begin
          if (val == '0) n[i] = 1'b0;
        end else begin
          n[i] = |val;
        end
      end
      if (hw_set[i]) n[i] = 1'b1;
    end
    return n;
  endfunction

  function automatic logic irq_of(ev_vec_t ev, ev_vec_t en);
    return |(ev & en);
  endfunction
endpackage

// File: rtl/uart_evt_dec.sv
module uart_evt_dec
  import uart_evt_pkg::*;
(
  input  logic              enabled,
  input  logic              bus_wr,
  input  logic [OFF_W-1:0]  bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic              tx_go,
  output logic              tx_halt,
  output logic              rx_go,
  output logic              rx_halt,
  output logic              pause,
  output logic              en_on,
  output logic              en_off,
  output ev_vec_t           ev_wr,
  output logic              ien_wr,
  output logic              ien_set,
  output logic              ien_clr,
  output logic              errsrc_wr,
  output logic              txd_wr,
  output logic [CFG_N-1:0]  cfg_wr
);
  logic live;
  logic trig;
  logic en_hit;

  assign live   = bus_wr && enabled;
  assign trig   = live && (bus_wdata == DW'(1));
  assign en_hit = bus_wr && (bus_addr == A_ENABLE);

  assign tx_go   = trig && (bus_addr == A_TX_GO);
  assign tx_halt = trig && (bus_addr == A_TX_HALT);
  assign rx_go   = trig && (bus_addr == A_RX_GO);
  assign rx_halt = trig && (bus_addr == A_RX_HALT);
  assign pause   = trig && (bus_addr == A_PAUSE);

  // ENABLE is the only offset honoured while disabled.
  assign en_on  = en_hit && (bus_wdata == EN_KEY);
  assign en_off = en_hit && (bus_wdata == '0);

  assign ien_wr    = live && (bus_addr == A_IEN);
  assign ien_set   = live && (bus_addr == A_IEN_SET);
  assign ien_clr   = live && (bus_addr == A_IEN_CLR);
  assign errsrc_wr = live && (bus_addr == A_ERRSRC);
  assign txd_wr    = live && (bus_addr == A_TXD);

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    assign ev_wr[g] = live && (bus_addr == ev_off(g));
  end

  for (genvar g = 0; g < CFG_N; g++) begin : g_cfg
    assign cfg_wr[g] = live && (bus_addr == cfg_off(g));
  end
endmodule

// File: rtl/uart_evt_run.sv
module uart_evt_run (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_go,
  input  logic tx_halt,
  input  logic rx_go,
  input  logic rx_halt,
  input  logic pause,
  input  logic en_on,
  input  logic en_off,
  output logic enabled,
  output logic tx_run,
  output logic rx_run,
  output logic rxto_set
);
  logic tx_stop;
  logic rx_stop;

  // Disabling acts as both stop tasks; TX halt alone leaves RX untouched.
  assign tx_stop  = tx_halt | pause | en_off;
  assign rx_stop  = rx_halt | pause | en_off;
  assign rxto_set = rx_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      tx_run  <= 1'b0;
      rx_run  <= 1'b0;
    end else begin
      if (en_on)       enabled <= 1'b1;
      else if (en_off) enabled <= 1'b0;
      if (tx_stop)     tx_run <= 1'b0;
      else if (tx_go)  tx_run <= 1'b1;
      if (rx_stop)     rx_run <= 1'b0;
      else if (rx_go)  rx_run <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_evt_flags.sv
module uart_evt_flags
  import uart_evt_pkg::*;
#(
  parameter int               ERR_W    = 4,
  parameter logic [ERR_W-1:0] BRK_BITS = ERR_W'(3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    wdata,
  input  ev_vec_t          ev_wr,
  input  ev_vec_t          hw_set,
  input  logic             ien_wr,
  input  logic             ien_set,
  input  logic             ien_clr,
  input  logic             errsrc_wr,
  input  logic             brk,
  output ev_vec_t          ev_q,
  output ev_vec_t          ien_q,
  output logic [ERR_W-1:0] errsrc_q,
  output logic             irq
);
  ev_vec_t          ev_n;
  ev_vec_t          ien_n;
  logic [ERR_W-1:0] errsrc_n;

  assign ev_n  = ev_step(ev_q, ev_wr, wdata, hw_set);
  assign ien_n = ien_apply(ien_q, wdata[NUM_EV-1:0], ien_wr, ien_set, ien_clr);

  always_comb begin
    errsrc_n = errsrc_q;
    if (errsrc_wr) errsrc_n = errsrc_n & ~wdata[ERR_W-1:0];
    if (brk)       errsrc_n = errsrc_n | BRK_BITS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q     <= '0;
      ien_q    <= '0;
      errsrc_q <= '0;
    end else begin
      ev_q     <= ev_n;
      ien_q    <= ien_n;
      errsrc_q <= errsrc_n;
    end
  end

  assign irq = irq_of(ev_q, ien_q);
endmodule

// File: rtl/uart_evt_txhold.sv
module uart_evt_txhold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txd_wr,
  input  logic              tx_run,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              tx_done,
  output logic              pending,
  output logic              handoff,
  output logic              tx_start,
  output logic [BYTE_W-1:0] tx_byte
);
  logic accept;

  assign accept  = txd_wr && tx_run && !pending;
  assign handoff = pending && tx_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      tx_start <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_start <= accept;
      if (accept) begin
        pending <= 1'b1;
        tx_byte <= wbyte;
      end else if (handoff) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_evt_ctrl.sv
module uart_evt_ctrl
  import uart_evt_pkg::*;
#(
  parameter int            BYTE_W    = 8,
  parameter int            ERR_W     = 4,
  parameter logic [DW-1:0] BAUD_INIT = BAUD_RST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [OFF_W-1:0]  bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              rx_evt,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              brk,
  input  logic              tx_done,
  output logic              tx_start,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);
  logic tx_go, tx_halt, rx_go, rx_halt, pause, en_on, en_off;
  logic ien_wr, ien_set, ien_clr, errsrc_wr, txd_wr;
  logic [CFG_N-1:0] cfg_wr;
  ev_vec_t ev_wr;
  ev_vec_t hw_set;
  ev_vec_t ev_q;
  ev_vec_t ien_q;
  logic [ERR_W-1:0] errsrc_q;
  logic enabled, tx_run, rx_run, rxto_set;
  logic pending, handoff;
  logic [DW-1:0] cfg_q [CFG_N];

  uart_evt_dec u_dec (
    .enabled   (enabled),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tx_go     (tx_go),
    .tx_halt   (tx_halt),
    .rx_go     (rx_go),
    .rx_halt   (rx_halt),
    .pause     (pause),
    .en_on     (en_on),
    .en_off    (en_off),
    .ev_wr     (ev_wr),
    .ien_wr    (ien_wr),
    .ien_set   (ien_set),
    .ien_clr   (ien_clr),
    .errsrc_wr (errsrc_wr),
    .txd_wr    (txd_wr),
    .cfg_wr    (cfg_wr)
  );

  uart_evt_run u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_go    (tx_go),
    .tx_halt  (tx_halt),
    .rx_go    (rx_go),
    .rx_halt  (rx_halt),
    .pause    (pause),
    .en_on    (en_on),
    .en_off   (en_off),
    .enabled  (enabled),
    .tx_run   (tx_run),
    .rx_run   (rx_run),
    .rxto_set (rxto_set)
  );

  always_comb begin
    hw_set           = '0;
    hw_set[EV_RXRDY] = rx_evt && rx_run;
    hw_set[EV_TXRDY] = handoff;
    hw_set[EV_ERR]   = brk;
    hw_set[EV_RXTO]  = rxto_set;
  end

  uart_evt_flags #(.ERR_W(ERR_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdata     (bus_wdata),
    .ev_wr     (ev_wr),
    .hw_set    (hw_set),
    .ien_wr    (ien_wr),
    .ien_set   (ien_set),
    .ien_clr   (ien_clr),
    .errsrc_wr (errsrc_wr),
    .brk       (brk),
    .ev_q      (ev_q),
    .ien_q     (ien_q),
    .errsrc_q  (errsrc_q),
    .irq       (irq)
  );

  uart_evt_txhold #(.BYTE_W(BYTE_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .txd_wr   (txd_wr),
    .tx_run   (tx_run),
    .wbyte    (bus_wdata[BYTE_W-1:0]),
    .tx_done  (tx_done),
    .pending  (pending),
    .handoff  (handoff),
    .tx_start (tx_start),
    .tx_byte  (tx_byte)
  );

  // Pin-select words reset to all ones, the last word is the baud setting.
  for (genvar g = 0; g < CFG_N; g++) begin : g_cfg
    localparam logic [DW-1:0] RST_VAL = (g < PSEL_N) ? '1 : BAUD_INIT;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_q[g] <= RST_VAL;
      else if (cfg_wr[g]) cfg_q[g] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (enabled) begin
      case (bus_addr)
        A_EV_RXRDY: bus_rdata = DW'(ev_q[EV_RXRDY]);
        A_EV_TXRDY: bus_rdata = DW'(ev_q[EV_TXRDY]);
        A_EV_ERR:   bus_rdata = DW'(ev_q[EV_ERR]);
        A_EV_RXTO:  bus_rdata = DW'(ev_q[EV_RXTO]);
        A_IEN, A_IEN_SET, A_IEN_CLR: bus_rdata = DW'(ien_q);
        A_ERRSRC:   bus_rdata = DW'(errsrc_q);
        A_ENABLE:   bus_rdata = EN_KEY;
        A_RXD:      bus_rdata = DW'(rx_data);
        default:    bus_rdata = '0;
      endcase
      for (int i = 0; i < CFG_N; i++) begin
        if (bus_addr == cfg_off(i)) bus_rdata = cfg_q[i];
      end
    end
  end
endmodule

// File: rtl/uart_evt_ctrl_chk.sv
module uart_evt_ctrl_chk
  import uart_evt_pkg::*;
#(
  parameter int ERR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [OFF_W-1:0] bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic             brk,
  input logic             tx_done,
  input logic             tx_start,
  input logic             irq,
  input logic             enabled,
  input logic             rx_run,
  input logic             pending,
  input ev_vec_t          ev_q,
  input ev_vec_t          ien_q,
  input logic [ERR_W-1:0] errsrc_q
);
  // R2
  en_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ENABLE && bus_wdata == EN_KEY) |=> enabled);

  // R2
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ENABLE && bus_wdata == '0)
      |=> (!enabled && !rx_run && ev_q[EV_RXTO]));

  // R3
  rd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> (bus_rdata == '0));

  // R3
  wr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && bus_wr && bus_addr != A_ENABLE && !brk)
      |=> ($stable(ien_q) && $stable(errsrc_q) && !tx_start));

  // R4
  ien_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && bus_wr && bus_addr == A_IEN_CLR)
      |=> ((ien_q & $past(bus_wdata[NUM_EV-1:0])) == '0));

  // R5
  irq_mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && bus_wr && bus_addr == A_IEN && bus_wdata[NUM_EV-1:0] == '0)
      |=> !irq);

  // R9
  brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> (errsrc_q[1:0] == 2'b11 && ev_q[EV_ERR]));

  // R11
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  // R12
  handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && tx_done) |=> (!pending && ev_q[EV_TXRDY]));
endmodule

bind uart_evt_ctrl uart_evt_ctrl_chk #(.ERR_W(ERR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .brk       (brk),
  .tx_done   (tx_done),
  .tx_start  (tx_start),
  .irq       (irq),
  .enabled   (enabled),
  .rx_run    (rx_run),
  .pending   (pending),
  .ev_q      (ev_q),
  .ien_q     (ien_q),
  .errsrc_q  (errsrc_q)
);

// File: tb/uart_evt_ctrl_tb.sv
module uart_evt_ctrl_tb;
  import uart_evt_pkg::*;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          rx_evt = 1'b0;
  logic [7:0]    rx_data = 8'hC3;
  logic          brk = 1'b0;
  logic          tx_done = 1'b0;
  logic          tx_start;
  logic [7:0]    tx_byte;
  logic          irq;

  int vecs = 0;
  int bad  = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_evt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_evt(rx_evt),
    .rx_data(rx_data), .brk(brk), .tx_done(tx_done), .tx_start(tx_start),
    .tx_byte(tx_byte), .irq(irq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdchk(string req, string what, logic [4:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(req, what, bus_rdata, exp);
  endtask

  task automatic pulse_rx();
    @(negedge clk); rx_evt = 1'b1;
    @(negedge clk); rx_evt = 1'b0;
  endtask

  task automatic pulse_brk();
    @(negedge clk); brk = 1'b1;
    @(negedge clk); brk = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic clear_events();
    wr(A_EV_RXRDY, 0); wr(A_EV_TXRDY, 0); wr(A_EV_ERR, 0); wr(A_EV_RXTO, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: outputs idle after reset
    chk("R1", "irq after reset", 32'(irq), 0);
    chk("R1", "tx_start after reset", 32'(tx_start), 0);
    // R3: every offset reads zero while disabled
    for (int a = 0; a < 32; a++) rdchk("R3", "read while disabled", 5'(a), 0);

    // R2 / R3: non-key values do not enable; writes while disabled are lost
    for (int v = 1; v < 8; v++) begin
      if (v == 4) continue;
      wr(A_ENABLE, 32'(v));
      wr(A_IEN, 32'hF);
    end
    rdchk("R2", "ENABLE still off", A_ENABLE, 0);
    wr(A_ENABLE, EN_KEY);
    rdchk("R2", "ENABLE reads key", A_ENABLE, 4);
    // R1: reset values
    rdchk("R1", "IEN reset", A_IEN, 0);
    rdchk("R1", "ERRSRC reset", A_ERRSRC, 0);
    for (int i = 0; i < NUM_EV; i++) rdchk("R1", "event reset", ev_off(i), 0);
    for (int i = 0; i < PSEL_N; i++) rdchk("R1", "pin select reset", cfg_off(i), 32'hFFFF_FFFF);
    rdchk("R1", "baud reset", A_BAUD, 32'h0400_0000);
    wr(A_ENABLE, 32'd5);
    rdchk("R2", "ENABLE after odd value", A_ENABLE, 4);

    // R4: full sweep of replace / set / clear
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        wr(A_IEN, 32'hABCD_0000 | 32'(a));
        wr(A_IEN_SET, 32'(b));
        rdchk("R4", "IEN after set", A_IEN, 32'(a | b));
        rdchk("R4", "IEN_SET view", A_IEN_SET, 32'(a | b));
        wr(A_IEN_CLR, 32'(b));
        rdchk("R4", "IEN_CLR view", A_IEN_CLR, 32'((a | b) & ~b & 15));
      end
    end

    // R5: event pattern x mask sweep, irq drops when events clear
    wr(A_RX_GO, 1);
    for (int e = 0; e < 16; e++) begin
      for (int m = 0; m < 16; m++) begin
        clear_events();
        wr(A_EV_TXRDY, 32'(e >> 1 & 1));
        wr(A_EV_ERR,   32'(e >> 2 & 1));
        wr(A_EV_RXTO,  32'(e >> 3 & 1));
        if (e[0]) pulse_rx();
        wr(A_IEN, 32'(m));
        chk("R5", "irq vs events&mask", 32'(irq), 32'((e & m) != 0));
        if (m == 15)
          for (int i = 0; i < NUM_EV; i++)
            rdchk("R10", "event readback", ev_off(i), 32'(e >> i & 1));
        clear_events();
        chk("R5", "irq after clearing events", 32'(irq), 0);
      end
    end
    wr(A_IEN, 0);

    // R10: RXRDY only cleared by zero, RXD read/write
    pulse_rx();
    wr(A_EV_RXRDY, 7);
    rdchk("R10", "RXRDY kept by nonzero write", A_EV_RXRDY, 1);
    wr(A_EV_RXRDY, 0);
    wr(A_EV_RXRDY, 5);
    rdchk("R10", "RXRDY not set by software", A_EV_RXRDY, 0);
    wr(A_RXD, 32'h55);
    rdchk("R10", "RXD returns rx_data", A_RXD, 32'hC3);

    // R7: RX halt stops receive and raises timeout
    wr(A_RX_HALT, 1);
    rdchk("R7", "RXTO after RX halt", A_EV_RXTO, 1);
    pulse_rx();
    rdchk("R7", "rx_evt ignored after halt", A_EV_RXRDY, 0);
    wr(A_EV_RXTO, 0);
    // R6: only the value 1 triggers
    wr(A_RX_GO, 2);
    pulse_rx();
    rdchk("R6", "RX_GO with 2 ignored", A_EV_RXRDY, 0);
    wr(A_RX_GO, 1);
    pulse_rx();
    rdchk("R6", "RX_GO with 1 starts", A_EV_RXRDY, 1);
    wr(A_EV_RXRDY, 0);
    wr(A_TX_GO, 3);
    wr(A_TXD, 32'h44);
    chk("R6", "TX_GO with 3 ignored", 32'(tx_start), 0);

    // R11: transmit hand-off
    wr(A_TX_GO, 1);
    wr(A_TXD, 32'h1234_565A);
    chk("R11", "tx_start after TXD", 32'(tx_start), 1);
    chk("R11", "tx_byte", 32'(tx_byte), 32'h5A);
    @(negedge clk);
    chk("R11", "tx_start one cycle", 32'(tx_start), 0);
    wr(A_TXD, 32'h33);
    chk("R11", "TXD refused while pending", 32'(tx_start), 0);
    chk("R11", "tx_byte kept while pending", 32'(tx_byte), 32'h5A);
    // R12: hand-off sets TXRDY
    pulse_done();
    rdchk("R12", "TXRDY after tx_done", A_EV_TXRDY, 1);
    wr(A_EV_TXRDY, 0);
    pulse_done();
    rdchk("R12", "tx_done with nothing pending", A_EV_TXRDY, 0);
    wr(A_TXD, 32'h77);
    chk("R12", "accept after hand-off", 32'(tx_start), 1);
    wr(A_EV_TXRDY, 1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_EV_TXRDY; bus_wdata = 0; tx_done = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tx_done = 1'b0;
    rdchk("R12", "hardware set wins", A_EV_TXRDY, 1);

    // R7: TX halt leaves RX and RXTO alone
    wr(A_EV_RXTO, 0);
    wr(A_TX_HALT, 1);
    wr(A_TXD, 32'h11);
    chk("R7", "TXD refused after TX halt", 32'(tx_start), 0);
    rdchk("R7", "RXTO untouched by TX halt", A_EV_RXTO, 0);
    pulse_rx();
    rdchk("R7", "RX still runs", A_EV_RXRDY, 1);

    // R8: pause stops both and raises timeout
    wr(A_EV_RXRDY, 0);
    wr(A_TX_GO, 1);
    wr(A_PAUSE, 1);
    rdchk("R8", "RXTO after pause", A_EV_RXTO, 1);
    wr(A_TXD, 32'h22);
    chk("R8", "TX stopped by pause", 32'(tx_start), 0);
    pulse_rx();
    rdchk("R8", "RX stopped by pause", A_EV_RXRDY, 0);

    // R9: error source
    pulse_brk();
    rdchk("R9", "ERRSRC after break", A_ERRSRC, 3);
    rdchk("R9", "ERR after break", A_EV_ERR, 1);
    wr(A_ERRSRC, 1);
    rdchk("R9", "ERRSRC clear bit 0", A_ERRSRC, 2);
    wr(A_ERRSRC, 32'hFFFF_FFFE);
    rdchk("R9", "ERRSRC clear rest", A_ERRSRC, 0);
    wr(A_EV_ERR, 0);
    rdchk("R10", "ERR cleared by software", A_EV_ERR, 0);

    // R2: disable stops both sides, sets RXTO, keeps irq logic alive
    wr(A_IEN, 32'h8);
    wr(A_EV_RXTO, 0);
    chk("R5", "irq low before disable", 32'(irq), 0);
    wr(A_TX_GO, 1);
    wr(A_RX_GO, 1);
    wr(A_ENABLE, 0);
    chk("R2", "irq from RXTO on disable", 32'(irq), 1);
    rdchk("R3", "IEN reads zero disabled", A_IEN, 0);
    // R3: every offset except ENABLE ignored while disabled
    for (int a = 0; a < 32; a++) begin
      if (5'(a) == A_ENABLE) continue;
      wr(5'(a), 1);
      chk("R3", "no tx_start while disabled", 32'(tx_start), 0);
      wr(5'(a), 32'hFFFF_FFFF);
    end
    chk("R3", "irq unchanged while disabled", 32'(irq), 1);
    wr(A_ENABLE, EN_KEY);
    rdchk("R3", "IEN kept", A_IEN, 8);
    rdchk("R3", "ERRSRC kept", A_ERRSRC, 0);
    rdchk("R3", "pin select kept", cfg_off(0), 32'hFFFF_FFFF);
    rdchk("R3", "baud kept", A_BAUD, 32'h0400_0000);
    rdchk("R2", "RXTO set by disable", A_EV_RXTO, 1);
    wr(A_TXD, 32'h12);
    chk("R2", "TX stopped by disable", 32'(tx_start), 0);
    wr(A_EV_RXRDY, 0);
    pulse_rx();
    rdchk("R2", "RX stopped by disable", A_EV_RXRDY, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule